// File: doc/BRIEF.md
# NOR Flash Block Erase Sequencer

This controller erases a single erase block of a parallel NOR flash that speaks the extended command set. A pulse on `start` captures the word address of the block. The controller then drives a simple synchronous bus master. It writes the erase setup command and the erase confirm command to that address. After that it reads the status register from the same address, again and again, until every interleaved chip lane reports ready or a cycle-counted timeout runs out. The timeout is 1500 ms by default.

When the erase ends, the controller emits a one-cycle `done` pulse. Alongside the pulse it presents the merged 8-bit status and a one-hot error code. After any failure it writes the status-clear command. In every case its last write returns the array to read mode. Several chips can sit side by side on one data bus: `LANES` copies of each 8-bit command are driven at once, and each lane's status is read back at once.

The sequence runs through seven states:

- **IDLE** goes to SETUP on `start`.
- **SETUP** writes 0x20 and goes to CONFIRM.
- **CONFIRM** writes 0xD0 and goes to POLL.
- **POLL** issues a read and goes to EVAL.
- **EVAL** looks at the read data. It goes to ARRAY when all lanes are ready with no error. It goes to CLEAR when all lanes are ready with an error, or when the timer has expired. Otherwise it goes back to POLL.
- **CLEAR** writes 0x50 and goes to ARRAY.
- **ARRAY** writes 0xFF, pulses `done` and returns to IDLE.

Top module: `nor_erase_seq`

## Requirements
- R1: After reset the block is idle: `bus_we`, `bus_re` and `done` are 0, and `status` and `err_code` are 0.
- R2: A `start` seen in IDLE latches `blk_addr`. In the next cycle the block writes 0x20 in every lane to that address, and in the cycle after that it writes 0xD0 in every lane to the same address.
- R3: After the confirm write, the block alternates a read cycle (`bus_re`=1) with an evaluation cycle in which the bus is quiet. Every read targets the latched address. Read data is taken in the cycle that follows `bus_re`.
- R4: The erase counts as complete only when bit 7 of the status is set in every lane. If any lane still shows bit 7 clear, polling goes on.
- R5: If the erase completes with none of bits 5, 4, 3 and 1 set in any lane, the next cycle writes 0xFF and pulses `done` with `err_code`=0. No 0x50 is written.
- R6: `err_code` is one-hot, and each error bit is ORed across lanes. Bit 0 means lock (status bit 1), bit 1 means low voltage (status bit 3), and bit 2 means I/O error (status bit 4 or bit 5). When several are present, lock wins over voltage, and voltage wins over I/O.
- R7: After an error or a timeout, the block writes 0x50 and then writes 0xFF. `done` rises in the same cycle as the 0xFF write and lasts one cycle.
- R8: Let LIMIT = CLK_HZ/1000 × TIMEOUT_MS. A timeout occurs at the first evaluation cycle, still not ready, that comes at least LIMIT cycles after the first poll read. It reports `err_code` bit 3.
- R9: A `start` while a sequence is in progress is ignored, and the latched address does not change.
- R10: While `done` is high, `status` shows the last sampled status merged across lanes: bit 7 is the AND of the lanes' bit 7, and every other bit is the OR across the lanes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an erase (acted on only when idle) |
| blk_addr | input | ADDR_W | Word address of the block to erase |
| bus_addr | output | ADDR_W | Bus address |
| bus_wdata | output | 8×LANES | Bus write data |
| bus_we | output | 1 | Bus write strobe |
| bus_re | output | 1 | Bus read strobe; data is returned the next cycle |
| bus_rdata | input | 8×LANES | Bus read data |
| done | output | 1 | One-cycle end-of-erase pulse |
| status | output | 8 | Merged status, valid with `done` |
| err_code | output | 4 | One-hot error code: timeout, I/O, voltage, lock (MSB to LSB) |

## Verification
The properties assume that `bus_rdata` returns the addressed status in the cycle after `bus_re`. They also assume that `start` is a single-cycle pulse, either issued in IDLE or meant to be ignored. The bench's flash model answers each read one cycle later with a scripted sequence: busy values, then a final status, or busy forever to force a timeout. The stimulus covers these cases:

- a lane that goes ready ahead of the other lane;
- status values that carry several error bits at once;
- a stray `start` with a different address issued mid-poll.

// File: rtl/nor_erase_pkg.sv
package nor_erase_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SETUP,
        S_CONFIRM,
        S_POLL,
        S_EVAL,
        S_CLEAR,
        S_ARRAY
    } seq_state_t;

    localparam logic [7:0] CMD_SETUP   = 8'h20;
    localparam logic [7:0] CMD_CONFIRM = 8'hD0;
    localparam logic [7:0] CMD_CLEAR   = 8'h50;
    localparam logic [7:0] CMD_ARRAY   = 8'hFF;

    localparam int BIT_READY = 7;
    localparam int BIT_ERASE = 5;
    localparam int BIT_PROG  = 4;
    localparam int BIT_VOLT  = 3;
    localparam int BIT_LOCK  = 1;

    localparam int CODE_W    = 4;
    localparam int CODE_LOCK = 0;
    localparam int CODE_VOLT = 1;
    localparam int CODE_IO   = 2;
    localparam int CODE_TIME = 3;

endpackage

// File: rtl/nor_status_merge.sv
module nor_status_merge #(
    parameter int LANES = 1
) (
    input  logic [8*LANES-1:0] rdata,
    output logic               all_ready,
    output logic [7:0]         merged
);
    import nor_erase_pkg::*;

    always_comb begin
        merged    = '0;
        all_ready = 1'b1;
        for (int i = 0; i < LANES; i++) begin
            merged    = merged | rdata[8*i +: 8];
            all_ready = all_ready & rdata[8*i + BIT_READY];
        end
        merged[BIT_READY] = all_ready;
    end

endmodule

// File: rtl/nor_status_classify.sv
module nor_status_classify
    import nor_erase_pkg::*;
(
    input  logic [7:0]        merged,
    output logic [CODE_W-1:0] code
);
    always_comb begin
        code = '0;
        if (merged[BIT_LOCK])
            code[CODE_LOCK] = 1'b1;
        else if (merged[BIT_VOLT])
            code[CODE_VOLT] = 1'b1;
        else if (merged[BIT_PROG] || merged[BIT_ERASE])
            code[CODE_IO] = 1'b1;
    end

endmodule

// File: rtl/nor_erase_timer.sv
module nor_erase_timer #(
    parameter int unsigned LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic expired
);
    localparam int CNT_W = $clog2(LIMIT + 2);
    localparam logic [CNT_W-1:0] LIM = CNT_W'(LIMIT);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            cnt <= '0;
        else if (run && cnt != LIM)
            cnt <= cnt + 1'b1;
    end

    assign expired = (cnt >= LIM);

endmodule

// File: rtl/nor_erase_seq.sv
module nor_erase_seq
    import nor_erase_pkg::*;
#(
    parameter int          ADDR_W     = 24,
    parameter int          LANES      = 1,
    parameter int unsigned CLK_HZ     = 50_000_000,
    parameter int unsigned TIMEOUT_MS = 1500
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [ADDR_W-1:0]   blk_addr,
    output logic [ADDR_W-1:0]   bus_addr,
    output logic [8*LANES-1:0]  bus_wdata,
    output logic                bus_we,
    output logic                bus_re,
    input  logic [8*LANES-1:0]  bus_rdata,
    output logic                done,
    output logic [7:0]          status,
    output logic [CODE_W-1:0]   err_code
);
    localparam int          DW        = 8 * LANES;
    localparam int unsigned CYC_PER_MS = CLK_HZ / 1000;
    localparam int unsigned LIMIT     = CYC_PER_MS * TIMEOUT_MS;

    seq_state_t          state, nxt;
    logic [ADDR_W-1:0]   addr_q;
    logic [7:0]          status_q;
    logic [CODE_W-1:0]   code_q;
    logic                all_ready;
    logic [7:0]          merged;
    logic [CODE_W-1:0]   cls_code;
    logic                expired;

    nor_status_merge #(.LANES(LANES)) u_merge (
        .rdata     (bus_rdata),
        .all_ready (all_ready),
        .merged    (merged)
    );

    nor_status_classify u_cls (
        .merged (merged),
        .code   (cls_code)
    );

    nor_erase_timer #(.LIMIT(LIMIT)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (state == S_CONFIRM),
        .run     (state == S_POLL || state == S_EVAL),
        .expired (expired)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= S_IDLE;
        else
            state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:    if (start) nxt = S_SETUP;
            S_SETUP:   nxt = S_CONFIRM;
            S_CONFIRM: nxt = S_POLL;
            S_POLL:    nxt = S_EVAL;
            S_EVAL: begin
                if (all_ready)
                    nxt = (cls_code != '0) ? S_CLEAR : S_ARRAY;
                else if (expired)
                    nxt = S_CLEAR;
                else
                    nxt = S_POLL;
            end
            S_CLEAR:   nxt = S_ARRAY;
            S_ARRAY:   nxt = S_IDLE;
            default:   nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q   <= '0;
            status_q <= '0;
            code_q   <= '0;
        end else begin
            if (state == S_IDLE && start)
                addr_q <= blk_addr;
            if (state == S_EVAL && (all_ready || expired)) begin
                status_q <= merged;
                if (all_ready)
                    code_q <= cls_code;
                else
                    code_q <= CODE_W'(1) << CODE_TIME;
            end
        end
    end

    always_comb begin
        bus_we    = 1'b0;
        bus_re    = 1'b0;
        bus_wdata = '0;
        done      = 1'b0;
        unique case (state)
            S_SETUP:   begin bus_we = 1'b1; bus_wdata = {LANES{CMD_SETUP}};   end
            S_CONFIRM: begin bus_we = 1'b1; bus_wdata = {LANES{CMD_CONFIRM}}; end
            S_POLL:    bus_re = 1'b1;
            S_CLEAR:   begin bus_we = 1'b1; bus_wdata = {LANES{CMD_CLEAR}};   end
            S_ARRAY:   begin bus_we = 1'b1; bus_wdata = {LANES{CMD_ARRAY}}; done = 1'b1; end
            default:   ;
        endcase
    end

    assign bus_addr = addr_q;
    assign status   = status_q;
    assign err_code = code_q;

    logic [DW-1:0] unused_dw;
    assign unused_dw = '0;

endmodule

// File: rtl/nor_erase_seq_chk.sv
module nor_erase_seq_chk
    import nor_erase_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int LANES  = 1
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start,
    input seq_state_t          state,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [8*LANES-1:0]  bus_wdata,
    input logic                bus_we,
    input logic                bus_re,
    input logic                done,
    input logic [CODE_W-1:0]   err_code
);
    // R2
    setup_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && start) |=> (bus_we && bus_wdata == {LANES{CMD_SETUP}}));

    // R3
    quiet_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_re |=> (!bus_re && !bus_we));

    // R6
    onehot_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $onehot0(err_code));

    // R7
    clear_before_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err_code != '0) |-> ($past(bus_we) && $past(bus_wdata) == {LANES{CMD_CLEAR}}));

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_IDLE) |=> $stable(bus_addr));

endmodule

bind nor_erase_seq nor_erase_seq_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .state     (state),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .done      (done),
    .err_code  (err_code)
);

// File: tb/nor_erase_seq_tb.sv
module nor_erase_seq_tb;
    localparam int AW     = 24;
    localparam int LN     = 2;
    localparam int HZ     = 20000;
    localparam int TMS    = 2;
    localparam int LIMIT  = HZ / 1000 * TMS;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] blk_addr = '0;
    logic [AW-1:0] bus_addr;
    logic [15:0]   bus_wdata;
    logic          bus_we, bus_re;
    logic [15:0]   bus_rdata = '0;
    logic          done;
    logic [7:0]    status;
    logic [3:0]    err_code;

    int vectors = 0;
    int fails = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    nor_erase_seq #(.ADDR_W(AW), .LANES(LN), .CLK_HZ(HZ), .TIMEOUT_MS(TMS)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .blk_addr(blk_addr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re),
        .bus_rdata(bus_rdata), .done(done), .status(status), .err_code(err_code)
    );

    // flash model: answers each read one cycle later
    int          rd_cnt = 0;
    int          rd_base = 0;
    int          cur_busy_n = 0;
    logic [15:0] cur_busy_v = '0;
    logic [15:0] cur_fin_v = '0;
    bit          cur_tmo = 0;

    always @(posedge clk) begin
        if (bus_re) begin
            rd_cnt    <= rd_cnt + 1;
            bus_rdata <= (cur_tmo || (rd_cnt - rd_base) < cur_busy_n) ? cur_busy_v : cur_fin_v;
        end
    end

    // expected per-cycle trace
    bit          e_we[$];
    bit          e_re[$];
    logic [15:0] e_wd[$];
    bit          e_done[$];
    string       e_tag[$];

    task automatic push(input bit we, input bit re, input logic [7:0] cmd, input bit dn, input string tag);
        e_we.push_back(we);
        e_re.push_back(re);
        e_wd.push_back({cmd, cmd});
        e_done.push_back(dn);
        e_tag.push_back(tag);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] merge(input logic [15:0] v);
        logic [7:0] m;
        m = v[15:8] | v[7:0];
        m[7] = v[15] & v[7];
        return m;
    endfunction

    function automatic logic [3:0] classify(input logic [7:0] m);
        if (m[1]) return 4'b0001;
        if (m[3]) return 4'b0010;
        if (m[4] || m[5]) return 4'b0100;
        return 4'b0000;
    endfunction

    task automatic run(input logic [AW-1:0] a, input int busy_n, input logic [15:0] busy_v,
                       input logic [15:0] fin_v, input bit tmo, input int ign_at, input string poll_tag);
        int          npoll;
        logic [7:0]  exp_st;
        logic [3:0]  exp_code;
        int          k;
        e_we.delete(); e_re.delete(); e_wd.delete(); e_done.delete(); e_tag.delete();
        if (tmo) begin
            k = 1;
            while (2 * k - 1 < LIMIT) k++;
            npoll    = k;
            exp_st   = merge(busy_v);
            exp_code = 4'b1000;
        end else begin
            npoll    = busy_n + 1;
            exp_st   = merge(fin_v);
            exp_code = classify(exp_st);
        end
        push(1, 0, 8'h20, 0, "R2");
        push(1, 0, 8'hD0, 0, "R2");
        for (int i = 0; i < npoll; i++) begin
            push(0, 1, 8'h00, 0, poll_tag);
            push(0, 0, 8'h00, 0, poll_tag);
        end
        if (exp_code != 0) push(1, 0, 8'h50, 0, "R7");
        push(1, 0, 8'hFF, 1, (exp_code != 0) ? "R7" : "R5");
        push(0, 0, 8'h00, 0, "R9");

        cur_busy_n = busy_n; cur_busy_v = busy_v; cur_fin_v = fin_v; cur_tmo = tmo;
        rd_base = rd_cnt;
        @(negedge clk);
        start = 1'b1; blk_addr = a;
        for (int j = 0; j < e_we.size(); j++) begin
            @(negedge clk);
            start = 1'b0; blk_addr = a;
            check({e_tag[j], " we"},   {31'd0, bus_we}, {31'd0, e_we[j]});
            check({e_tag[j], " re"},   {31'd0, bus_re}, {31'd0, e_re[j]});
            check({e_tag[j], " done"}, {31'd0, done},   {31'd0, e_done[j]});
            if (e_we[j]) check({e_tag[j], " wdata"}, {16'd0, bus_wdata}, {16'd0, e_wd[j]});
            if (e_we[j] || e_re[j]) check("R9 addr", {8'd0, bus_addr}, {8'd0, a});
            if (e_done[j]) begin
                check("R10 status", {24'd0, status}, {24'd0, exp_st});
                check(tmo ? "R8 code" : "R6 code", {28'd0, err_code}, {28'd0, exp_code});
            end
            if (j == ign_at) begin
                start = 1'b1; blk_addr = a ^ 24'h5A5A5A;
            end
        end
        start = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 we",     {31'd0, bus_we}, 0);
        check("R1 re",     {31'd0, bus_re}, 0);
        check("R1 done",   {31'd0, done},   0);
        check("R1 status", {24'd0, status}, 0);
        check("R1 code",   {28'd0, err_code}, 0);

        // R5 immediate success
        run(24'h010000, 0, 16'h0000, 16'h8080, 0, -1, "R3");
        // R4 one lane ready early, success after 3 busy polls
        run(24'h020000, 3, 16'h0080, 16'h8080, 0, -1, "R4");
        // R6 lock error in one lane only
        run(24'h030000, 1, 16'h0000, 16'h8280, 0, -1, "R3");
        // R6 low voltage
        run(24'h040000, 0, 16'h0000, 16'h8888, 0, -1, "R3");
        // R6 erase failure
        run(24'h050000, 0, 16'h0000, 16'h80A0, 0, -1, "R3");
        // R6 program failure
        run(24'h060000, 2, 16'h0000, 16'h9080, 0, -1, "R3");
        // R6 priority: lock beats voltage and erase
        run(24'h070000, 0, 16'h0000, 16'hAA80, 0, -1, "R3");
        // R6 priority: voltage beats program
        run(24'h080000, 0, 16'h0000, 16'h9898, 0, -1, "R3");
        // R8 timeout with partial lane, R9 stray start mid-poll
        run(24'h090000, 0, 16'h0080, 16'h8080, 1, 6, "R8");
        // R9 stray start during setup
        run(24'h0A0000, 1, 16'h0000, 16'h8080, 0, 0, "R3");

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule